// File: doc/BRIEF.md
# SPI Controller Interrupt Status Unit

This block holds the interrupt state of an SPI controller. Three kinds of event arrive as one-cycle pulses: a transfer has completed, received data is ready, and a received frame was lost because the receive store was full. Each pulse sets a sticky bit in a raw status vector. The bit then stays set until software clears it by writing a one to its position in a separate clear register.

The controller's control word holds three enable bits. These bits do not sit at the same positions as the status bits they gate, so the unit remaps them before it ANDs them with the raw status to form the masked status. The masked status follows the current raw state and control word in the same cycle. A single level-sensitive interrupt line is high whenever any masked bit is set.

A one-port register write interface carries a strobe, a target select and write data. A write to the clear register acts on the raw bits. A write aimed at the raw or masked status register is accepted and has no effect.

Top module: `spi_irq_status`

## Requirements
- R1: While `rst` is high at a rising clock edge, the raw status becomes 000. As a result, the masked status is 000 and `irq` is low.
- R2: The raw status bit layout is bit 0 = transfer done, bit 1 = receive ready, bit 2 = receive overflow. A pulse on `evt_done`, `evt_rx_ready` or `evt_rx_overflow` during a clock edge sets its bit from that edge on. The bit stays set until it is cleared.
- R3: A write with `wr_sel` = 0 (clear register) clears each raw bit whose `wr_data` bit (position 0, 1 or 2) is one. Raw bits whose data bit is zero are unchanged. `wr_data` bits 3 and above have no effect.
- R4: The masked status is formed as follows. Masked bit 0 = raw bit 0 AND `ctrl_word[5]`. Masked bit 1 = raw bit 1 AND `ctrl_word[4]`. Masked bit 2 = raw bit 2 AND `ctrl_word[6]`. No other control bit affects the masked status.
- R5: `irq` is high exactly when at least one masked status bit is set.
- R6: A write with `wr_sel` = 1 (raw status register) or `wr_sel` = 2 (masked status register) changes no raw bit, whatever the write data.
- R7: When an event pulse and a clear of the same bit fall on the same clock edge, the bit is set after that edge.
- R8: A change of `ctrl_word` alters the masked status and `irq` in the same cycle, without a clock edge, and leaves the raw status unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_done | input | 1 | Transfer-complete event pulse |
| evt_rx_ready | input | 1 | Receive-data-ready event pulse |
| evt_rx_overflow | input | 1 | Receive-overflow event pulse |
| ctrl_word | input | CTRL_W | Controller control word; bits 4, 5 and 6 are the enables |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 clear, 1 raw status, 2 masked status |
| wr_data | input | DATA_W | Write data |
| raw_status | output | 3 | Sticky raw interrupt status |
| masked_status | output | 3 | Raw status gated by the remapped enables |
| irq | output | 1 | Level interrupt, OR of the masked status |

## Verification
The bench builds the block with its default widths: a 32-bit control word and 32-bit write data. At these widths the bench can drive every control bit outside positions 4 to 6 high and show that those bits leave the masked status at zero. It can also write clear data in which only bits 3 to 31 are set and show that the raw bits survive. A vector table walks through set, gating, clear, ignored writes and the same-edge event-versus-clear race. Directed steps then cover reset in the middle of activity and enable changes made between clock edges.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

    localparam int unsigned NUM_SRC = 3;

    // Status bit positions
    localparam int unsigned ST_DONE = 0;
    localparam int unsigned ST_RXRDY = 1;
    localparam int unsigned ST_OVF = 2;

    // Enable bit positions inside the control word
    localparam int unsigned EN_POS_RXRDY = 4;
    localparam int unsigned EN_POS_DONE = 5;
    localparam int unsigned EN_POS_OVF = 6;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    typedef enum logic [1:0] {
        TGT_CLEAR = 2'd0,
        TGT_RAW = 2'd1,
        TGT_MASKED = 2'd2,
        TGT_NONE = 2'd3
    } wr_tgt_e;

    typedef struct packed {
        logic overflow;
        logic rx_ready;
        logic done;
    } src_bits_t;

    function automatic src_vec_t pack_src(input src_bits_t b);
        src_vec_t v;
        v[ST_DONE] = b.done;
        v[ST_RXRDY] = b.rx_ready;
        v[ST_OVF] = b.overflow;
        return v;
    endfunction

endpackage

// File: rtl/spi_irq_enable_map.sv
module spi_irq_enable_map
    import spi_irq_pkg::*;
#(
    parameter int unsigned CTRL_W = 32
) (
    input  logic [CTRL_W-1:0] ctrl_word,
    output src_vec_t          enables
);
    localparam int unsigned HI_USED = EN_POS_OVF;
    localparam int unsigned LO_USED = EN_POS_RXRDY;

    src_bits_t en_s;

    always_comb begin
        en_s.done = ctrl_word[EN_POS_DONE];
        en_s.rx_ready = ctrl_word[EN_POS_RXRDY];
        en_s.overflow = ctrl_word[EN_POS_OVF];
    end

    assign enables = pack_src(en_s);

    logic unused_ctrl_bits;
    assign unused_ctrl_bits = ^{ctrl_word[CTRL_W-1:HI_USED+1], ctrl_word[LO_USED-1:0]};
endmodule

// File: rtl/spi_irq_raw_bank.sv
module spi_irq_raw_bank
    import spi_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t set_pulse,
    input  src_vec_t clr_req,
    output src_vec_t raw_q
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                bit_q <= 1'b0;
            end else if (set_pulse[i]) begin
                bit_q <= 1'b1;
            end else if (clr_req[i]) begin
                bit_q <= 1'b0;
            end
        end
        assign raw_q[i] = bit_q;
    end
endmodule

// File: rtl/spi_irq_combine.sv
module spi_irq_combine
    import spi_irq_pkg::*;
(
    input  src_vec_t raw,
    input  src_vec_t enables,
    output src_vec_t masked,
    output logic     irq_line
);
    always_comb begin
        masked = raw & enables;
        irq_line = |masked;
    end
endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
    import spi_irq_pkg::*;
#(
    parameter int unsigned CTRL_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_done,
    input  logic              evt_rx_ready,
    input  logic              evt_rx_overflow,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [2:0]        raw_status,
    output logic [2:0]        masked_status,
    output logic              irq
);
    src_bits_t evt_s;
    src_vec_t  set_vec;
    src_vec_t  clr_vec;
    src_vec_t  en_vec;
    src_vec_t  raw_vec;
    src_vec_t  msk_vec;
    wr_tgt_e   tgt;

    always_comb begin
        evt_s.done = evt_done;
        evt_s.rx_ready = evt_rx_ready;
        evt_s.overflow = evt_rx_overflow;
    end

    assign set_vec = pack_src(evt_s);
    assign tgt = wr_tgt_e'(wr_sel);

    // Only the clear register acts; status registers swallow writes
    always_comb begin
        clr_vec = '0;
        if (wr_en && tgt == TGT_CLEAR) begin
            clr_vec = wr_data[NUM_SRC-1:0];
        end
    end

    logic unused_wdata_bits;
    assign unused_wdata_bits = ^wr_data[DATA_W-1:NUM_SRC];

    spi_irq_enable_map #(.CTRL_W(CTRL_W)) u_map (
        .ctrl_word(ctrl_word),
        .enables(en_vec)
    );

    spi_irq_raw_bank u_raw (
        .clk(clk),
        .rst(rst),
        .set_pulse(set_vec),
        .clr_req(clr_vec),
        .raw_q(raw_vec)
    );

    spi_irq_combine u_comb (
        .raw(raw_vec),
        .enables(en_vec),
        .masked(msk_vec),
        .irq_line(irq)
    );

    assign raw_status = raw_vec;
    assign masked_status = msk_vec;
endmodule

// File: rtl/spi_irq_status_chk.sv
module spi_irq_status_chk #(
    parameter int unsigned CTRL_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              evt_done,
    input logic              evt_rx_ready,
    input logic              evt_rx_overflow,
    input logic [CTRL_W-1:0] ctrl_word,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic [DATA_W-1:0] wr_data,
    input logic [2:0]        raw_status,
    input logic [2:0]        masked_status,
    input logic              irq
);
    logic [2:0] evts;
    logic [2:0] ens;
    logic       clr_wr;
    assign evts = {evt_rx_overflow, evt_rx_ready, evt_done};
    assign ens = {ctrl_word[6], ctrl_word[4], ctrl_word[5]};
    assign clr_wr = wr_en && (wr_sel == 2'd0);

    // R2 and R7: an event bit is set after its edge even when cleared
    assert_evt_sets_R2: assert property (@(posedge clk) disable iff (rst)
        (evts != 3'b000) |=> ((raw_status & $past(evts)) == $past(evts)));

    // R2: without a clear write, set bits stay set
    assert_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        !clr_wr |=> ((raw_status & $past(raw_status)) == $past(raw_status)));

    // R3: requested bits without a competing event drop
    assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
        clr_wr |=> ((raw_status & $past(wr_data[2:0] & ~evts)) == 3'b000));

    // R6: no bit rises without its event
    assert_no_spurious_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((raw_status & ~$past(raw_status) & ~$past(evts)) == 3'b000));

    // R4: gating follows the remapped enables
    assert_mask_map_R4: assert property (@(posedge clk) disable iff (rst)
        masked_status == (raw_status & ens));

    // R5: line level matches masked status
    assert_irq_level_R5: assert property (@(posedge clk) disable iff (rst)
        irq == (masked_status != 3'b000));
endmodule

bind spi_irq_status spi_irq_status_chk #(.CTRL_W(CTRL_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/spi_irq_status_tb.sv
module spi_irq_status_tb;
    localparam int unsigned NV = 13;

    // Row: evt[18:16] en{c6,c5,c4}[15:13] we[12] sel[11:10] data[9:7] raw[6:4] mask[3:1] irq[0]
    localparam logic [18:0] VECS [NV] = '{
        {3'b001, 3'b000, 1'b0, 2'd0, 3'b000, 3'b001, 3'b000, 1'b0},
        {3'b000, 3'b010, 1'b0, 2'd0, 3'b000, 3'b001, 3'b001, 1'b1},
        {3'b010, 3'b001, 1'b0, 2'd0, 3'b000, 3'b011, 3'b010, 1'b1},
        {3'b100, 3'b000, 1'b0, 2'd0, 3'b000, 3'b111, 3'b000, 1'b0},
        {3'b000, 3'b111, 1'b1, 2'd1, 3'b000, 3'b111, 3'b111, 1'b1},
        {3'b000, 3'b111, 1'b1, 2'd2, 3'b000, 3'b111, 3'b111, 1'b1},
        {3'b000, 3'b111, 1'b1, 2'd0, 3'b010, 3'b101, 3'b101, 1'b1},
        {3'b000, 3'b111, 1'b1, 2'd0, 3'b000, 3'b101, 3'b101, 1'b1},
        {3'b001, 3'b111, 1'b1, 2'd0, 3'b001, 3'b101, 3'b101, 1'b1},
        {3'b000, 3'b111, 1'b1, 2'd0, 3'b101, 3'b000, 3'b000, 1'b0},
        {3'b100, 3'b100, 1'b0, 2'd0, 3'b000, 3'b100, 3'b100, 1'b1},
        {3'b000, 3'b011, 1'b0, 2'd0, 3'b000, 3'b100, 3'b000, 1'b0},
        {3'b000, 3'b011, 1'b1, 2'd0, 3'b100, 3'b000, 3'b000, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        evt_done = 1'b0;
    logic        evt_rx_ready = 1'b0;
    logic        evt_rx_overflow = 1'b0;
    logic [31:0] ctrl_word = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic [2:0]  raw_status;
    logic [2:0]  masked_status;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #10 clk = ~clk;

    spi_irq_status u_dut (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] ev, input logic [31:0] cw,
                         input logic we, input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        {evt_rx_overflow, evt_rx_ready, evt_done} = ev;
        ctrl_word = cw;
        wr_en = we;
        wr_sel = sel;
        wr_data = d;
    endtask

    initial begin
        #2_000_000;
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 raw after reset", {29'd0, raw_status}, 32'd0);
        check("R1 irq after reset", {31'd0, irq}, 32'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [18:0] v;
            v = VECS[i];
            drive(v[18:16], {25'd0, v[15:13], 4'd0}, v[12], v[11:10], {29'd0, v[9:7]});
            @(negedge clk);
            check($sformatf("R2/R3/R6/R7 raw row %0d", i), {29'd0, raw_status}, {29'd0, v[6:4]});
            check($sformatf("R4 masked row %0d", i), {29'd0, masked_status}, {29'd0, v[3:1]});
            check($sformatf("R5 irq row %0d", i), {31'd0, irq}, {31'd0, v[0]});
        end

        // R4: every other control bit high, enables low
        drive(3'b111, 32'hFFFF_FF8F, 1'b0, 2'd0, 32'd0);
        drive(3'b000, 32'hFFFF_FF8F, 1'b0, 2'd0, 32'd0);
        check("R4 foreign ctrl bits masked", {29'd0, masked_status}, 32'd0);
        check("R5 irq low with foreign bits", {31'd0, irq}, 32'd0);

        // R3: clear data only above bit 2
        drive(3'b000, 32'd0, 1'b1, 2'd0, 32'hFFFF_FFF8);
        drive(3'b000, 32'd0, 1'b0, 2'd0, 32'd0);
        check("R3 upper clear bits ignored", {29'd0, raw_status}, 32'd7);

        // R6: all-ones writes to status registers
        drive(3'b000, 32'd0, 1'b1, 2'd1, 32'hFFFF_FFFF);
        drive(3'b000, 32'd0, 1'b1, 2'd2, 32'hFFFF_FFFF);
        drive(3'b000, 32'd0, 1'b0, 2'd0, 32'd0);
        check("R6 status writes ignored", {29'd0, raw_status}, 32'd7);

        // R8: enable changes between edges act at once
        @(negedge clk);
        #2 ctrl_word = 32'h0000_0040;
        #1 check("R8 masked follows enable", {29'd0, masked_status}, 32'd4);
        check("R8 irq follows enable", {31'd0, irq}, 32'd1);
        ctrl_word = 32'h0000_0010;
        #1 check("R8 masked rx enable", {29'd0, masked_status}, 32'd2);
        ctrl_word = 32'd0;
        #1 check("R8 irq drops", {31'd0, irq}, 32'd0);
        check("R8 raw untouched", {29'd0, raw_status}, 32'd7);

        // R1: reset in the middle of activity
        drive(3'b000, 32'h0000_0070, 1'b0, 2'd0, 32'd0);
        rst = 1'b1;
        @(negedge clk);
        check("R1 raw cleared by reset", {29'd0, raw_status}, 32'd0);
        check("R1 irq low after reset", {31'd0, irq}, 32'd0);
        rst = 1'b0;

        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule